// File: doc/BRIEF.md
# I/O Expander Command-Pointer Register File

This block is the register engine that sits behind the byte-level front end of a serial-bus I/O expander with forty pins. The pins are split into five banks of eight. The front end hands it whole bytes. The first byte of a write is a command byte, and every later byte is data, flowing either from the bus master or back to it. The block holds one command register. Its top bit enables automatic stepping, and its low six bits form a pointer made of a group field and a bank field.

There are five register groups, each with five banks:

- sampled inputs, read-only
- output values
- polarity inversion
- pin direction
- interrupt mask

The pointer steers each data byte to one bank of one group. A single-cycle acknowledge answers each written byte. The output, polarity, direction and mask banks are driven straight to the pin logic as forty-bit buses. Sampled pin values come back in and are read through the polarity inversion.

With stepping enabled, only the bank field moves. It walks banks 0 to 4 and then returns to 0. Bank codes above 4 are never visited. A stream longer than five bytes therefore overwrites from bank 0 again.

Top module: `iox_cmd_regfile`

## Requirements
- R1: After reset the command register holds 0x80 (stepping on, pointer 0). All output and polarity banks are 0x00, all direction and mask banks are 0xFF, and ackValid is low.
- R2: A write byte with byteIsCmd high is stored as the command. Bit 7 is the stepping flag. Bits 5:3 select the group (0 inputs, 1 outputs, 2 polarity, 3 direction, 4 mask). Bits 2:0 select the bank. A command byte is always acknowledged.
- R3: With bit 7 set, every data byte (read or written) advances bits 2:0 and leaves bits 7:3 unchanged. Bank 4 and the unused bank codes 5 to 7 all advance to bank 0, so a sixth written byte lands in bank 0.
- R4: With bit 7 clear, every data byte reads or writes the same bank, and the command register does not change.
- R5: A data byte written to a bank of groups 1 to 4 updates that bank. In the cycle after the byte, ackValid and ackOk are both high. ackValid pulses once for each written byte.
- R6: A data byte written while the pointer names the input group is not acknowledged (ackValid high, ackOk low) and changes no register.
- R7: When the pointer names a group above 4 or a bank above 4, the command is still stored. Data writes are not acknowledged and change nothing, and rdData is 0x00.
- R8: rdData for input bank n is pinIn[8n+7:8n] XOR polarity bank n.
- R9: Bank n of the output, polarity, direction and mask groups drives bits [8n+7:8n] of outPort, polInv, ioCfg and intMask respectively. These buses change only after a written byte.
- R10: rdData shows the bank named by the current pointer without delay. A read strobe (byteValid with byteWrite low) consumes it and applies the stepping of R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One byte transferred this cycle |
| byteWrite | input | 1 | 1: byte from master, 0: byte read by master |
| byteIsCmd | input | 1 | Marks the first (command) byte of a write |
| byteIn | input | 8 | Written byte |
| ackValid | output | 1 | Acknowledge decision valid (one cycle after a written byte) |
| ackOk | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| rdData | output | 8 | Byte at the current pointer |
| pinIn | input | 40 | Sampled pin levels, bank n at [8n+7:8n] |
| outPort | output | 40 | Output value banks |
| polInv | output | 40 | Polarity inversion banks |
| ioCfg | output | 40 | Direction banks (1 = input) |
| intMask | output | 40 | Interrupt mask banks |

## Verification
The checker watches several behaviours on every cycle:

- the group field never moves on a data byte, and the bank field always lands inside banks 0 to 4 when stepping is on
- the command holds still when stepping is off
- each acknowledge follows exactly one written byte, and input-group writes are refused
- pointers to unused codes read zero, and the output bus changes only after a written byte

The directed scenarios cover what the checker cannot see on its own: the reset values of each group, which bank a given byte lands in (including the sixth-byte overwrite and the skip from an unused code back to bank 0), and the polarity-inverted input reads.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int BYTE_W = 8;
  localparam int GRP_AW = 3;
  localparam int BANK_AW = 3;
  localparam int NUM_GROUPS = 5;
  localparam int STORED_GROUPS = NUM_GROUPS - 1;

  localparam logic [GRP_AW-1:0] GRP_IN = 3'd0;

  typedef struct packed {
    logic               wrEn;
    logic [GRP_AW-1:0]  grp;
    logic [BANK_AW-1:0] bank;
    logic [BYTE_W-1:0]  data;
  } regStrobe_t;
endpackage

// File: rtl/iox_ctrl.sv
module iox_ctrl
  import iox_pkg::*;
#(
  parameter int NUM_BANKS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic                byteWrite,
  input  logic                byteIsCmd,
  input  logic [BYTE_W-1:0]   byteIn,
  output logic [BYTE_W-1:0]   curCmd,
  output logic                ptrValid,
  output regStrobe_t          strobe,
  output logic                ackValid,
  output logic                ackOk
);
  logic [GRP_AW-1:0]  grp;
  logic [BANK_AW-1:0] bank;
  logic [BANK_AW-1:0] nextBank;
  logic cmdByte, wrData, rdByte, writable;

  assign grp  = curCmd[BANK_AW +: GRP_AW];
  assign bank = curCmd[BANK_AW-1:0];

  assign ptrValid = (int'(grp) < NUM_GROUPS) && (int'(bank) < NUM_BANKS);
  assign writable = ptrValid && (grp != GRP_IN);

  assign cmdByte = byteValid && byteWrite && byteIsCmd;
  assign wrData  = byteValid && byteWrite && !byteIsCmd;
  assign rdByte  = byteValid && !byteWrite;

  // unused bank codes fold back to bank 0 like the last bank
  assign nextBank = (int'(bank) >= NUM_BANKS - 1) ? '0 : bank + 1'b1;

  always_comb begin
    strobe.wrEn = wrData && writable;
    strobe.grp  = grp;
    strobe.bank = bank;
    strobe.data = byteIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCmd   <= 8'h80;
      ackValid <= 1'b0;
      ackOk    <= 1'b0;
    end else begin
      ackValid <= byteValid && byteWrite;
      ackOk    <= cmdByte || (wrData && writable);
      if (cmdByte) begin
        curCmd <= byteIn;
      end else if ((wrData || rdByte) && curCmd[BYTE_W-1]) begin
        curCmd[BANK_AW-1:0] <= nextBank;
      end
    end
  end
endmodule

// File: rtl/iox_datapath.sv
module iox_datapath
  import iox_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int PIN_W = NUM_BANKS * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic                ptrValid,
  input  logic [PIN_W-1:0]    pinIn,
  output logic [BYTE_W-1:0]   rdData,
  output logic [PIN_W-1:0]    outPort,
  output logic [PIN_W-1:0]    polInv,
  output logic [PIN_W-1:0]    ioCfg,
  output logic [PIN_W-1:0]    intMask
);
  logic [BYTE_W-1:0] bankReg [STORED_GROUPS][NUM_BANKS];
  logic [STORED_GROUPS-1:0][PIN_W-1:0] flatBus;

  // stored group index 0..3 maps to groups 1..4; direction and mask reset high
  function automatic logic [BYTE_W-1:0] resetVal(int g);
    return (g >= 2) ? '1 : '0;
  endfunction

  for (genvar g = 0; g < STORED_GROUPS; g++) begin : gGroup
    for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bankReg[g][b] <= resetVal(g);
        end else if (strobe.wrEn && int'(strobe.grp) == g + 1 &&
                     int'(strobe.bank) == b) begin
          bankReg[g][b] <= strobe.data;
        end
      end
      assign flatBus[g][b*BYTE_W +: BYTE_W] = bankReg[g][b];
    end
  end

  assign outPort = flatBus[0];
  assign polInv  = flatBus[1];
  assign ioCfg   = flatBus[2];
  assign intMask = flatBus[3];

  always_comb begin
    int bi;
    int gi;
    bi = int'(strobe.bank);
    gi = int'(strobe.grp);
    rdData = '0;
    if (ptrValid) begin
      if (gi == 0) rdData = pinIn[bi*BYTE_W +: BYTE_W] ^ bankReg[1][bi];
      else         rdData = bankReg[gi-1][bi];
    end
  end
endmodule

// File: rtl/iox_cmd_regfile.sv
module iox_cmd_regfile
  import iox_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int PIN_W = NUM_BANKS * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              byteWrite,
  input  logic              byteIsCmd,
  input  logic [7:0]        byteIn,
  output logic              ackValid,
  output logic              ackOk,
  output logic [7:0]        rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  outPort,
  output logic [PIN_W-1:0]  polInv,
  output logic [PIN_W-1:0]  ioCfg,
  output logic [PIN_W-1:0]  intMask
);
  regStrobe_t        strobe;
  logic              ptrValid;
  logic [BYTE_W-1:0] curCmd;

  iox_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteWrite(byteWrite),
    .byteIsCmd(byteIsCmd), .byteIn(byteIn), .curCmd(curCmd),
    .ptrValid(ptrValid), .strobe(strobe), .ackValid(ackValid), .ackOk(ackOk)
  );

  iox_datapath #(.NUM_BANKS(NUM_BANKS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptrValid(ptrValid),
    .pinIn(pinIn), .rdData(rdData), .outPort(outPort), .polInv(polInv),
    .ioCfg(ioCfg), .intMask(intMask)
  );
endmodule

// File: rtl/iox_cmd_regfile_chk.sv
module iox_cmd_regfile_chk #(
  parameter int NUM_BANKS = 5,
  parameter int PIN_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             byteWrite,
  input logic             byteIsCmd,
  input logic             ackValid,
  input logic             ackOk,
  input logic [7:0]       rdData,
  input logic [7:0]       curCmd,
  input logic [PIN_W-1:0] outPort
);
  logic dataByte;
  assign dataByte = byteValid && !(byteWrite && byteIsCmd);

  assert_group_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataByte |=> (curCmd[7:3] == $past(curCmd[7:3])));

  assert_bank_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && curCmd[7]) |=> (int'(curCmd[2:0]) < NUM_BANKS));

  assert_no_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && !curCmd[7]) |=> $stable(curCmd));

  assert_ack_follows_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid && byteWrite));

  assert_input_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteWrite && !byteIsCmd && curCmd[5:3] == 3'd0)
      |=> (ackValid && !ackOk));

  assert_unused_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(curCmd[2:0]) >= NUM_BANKS || int'(curCmd[5:3]) >= 5) |-> (rdData == 8'h00));

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && byteWrite) |=> $stable(outPort));
endmodule

bind iox_cmd_regfile iox_cmd_regfile_chk #(.NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W)) chk_i (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteWrite(byteWrite),
  .byteIsCmd(byteIsCmd), .ackValid(ackValid), .ackOk(ackOk), .rdData(rdData),
  .curCmd(curCmd), .outPort(outPort)
);

// File: tb/iox_cmd_regfile_tb_top.sv
module iox_cmd_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic        byteWrite = 1'b0;
  logic        byteIsCmd = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic        ackValid, ackOk;
  logic [7:0]  rdData;
  logic [39:0] pinIn = 40'h11_22_33_44_55;
  logic [39:0] outPort, polInv, ioCfg, intMask;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  iox_cmd_regfile dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteWrite(byteWrite),
    .byteIsCmd(byteIsCmd), .byteIn(byteIn), .ackValid(ackValid), .ackOk(ackOk),
    .rdData(rdData), .pinIn(pinIn), .outPort(outPort), .polInv(polInv),
    .ioCfg(ioCfg), .intMask(intMask)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one written byte, return the acknowledge pair seen the next cycle
  task automatic putByte(input logic isCmd, input logic [7:0] val,
                         output logic av, output logic ak);
    @(negedge clk);
    byteValid = 1'b1; byteWrite = 1'b1; byteIsCmd = isCmd; byteIn = val;
    @(negedge clk);
    byteValid = 1'b0; byteIsCmd = 1'b0;
    av = ackValid; ak = ackOk;
  endtask

  task automatic sendCmd(input logic [7:0] val);
    logic av, ak;
    putByte(1'b1, val, av, ak);
    check("R2 cmd ack", {av, ak}, 2'b11);
  endtask

  task automatic writeData(input logic [7:0] val, input logic expAck, input string req);
    logic av, ak;
    putByte(1'b0, val, av, ak);
    check(req, {av, ak}, {1'b1, expAck});
  endtask

  task automatic readData(input logic [7:0] exp, input string req);
    @(negedge clk);
    byteValid = 1'b1; byteWrite = 1'b0;
    check(req, rdData, exp);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 outPort", outPort, 40'h0);
    check("R1 polInv", polInv, 40'h0);
    check("R1 ioCfg", ioCfg, 40'hFF_FFFF_FFFF);
    check("R1 intMask", intMask, 40'hFF_FFFF_FFFF);
    check("R1 ackValid", ackValid, 1'b0);
    check("R1 R10 default pointer read", rdData, 8'h55);
  endtask

  task automatic testStepWrap();
    sendCmd(8'h88);
    for (int i = 0; i < 6; i++) writeData(8'hA0 + 8'(i), 1'b1, "R5 R3 output write ack");
    check("R3 R9 sixth byte overwrites bank 0", outPort, 40'hA4_A3_A2_A1_A5);
  endtask

  task automatic testNoStep();
    sendCmd(8'h12);
    writeData(8'h5A, 1'b1, "R4 write ack");
    writeData(8'h3C, 1'b1, "R4 write ack");
    writeData(8'hC3, 1'b1, "R4 write ack");
    check("R4 R9 same polarity bank", polInv, 40'h00_00_C3_00_00);
    readData(8'hC3, "R4 repeated read 1");
    readData(8'hC3, "R4 repeated read 2");
  endtask

  task automatic testInputWrite();
    sendCmd(8'h81);
    writeData(8'h77, 1'b0, "R6 input write nack");
    check("R6 outPort untouched", outPort, 40'hA4_A3_A2_A1_A5);
    check("R6 polInv untouched", polInv, 40'h00_00_C3_00_00);
    readData(8'hF0, "R6 R8 pointer stepped to bank 2, pin xor polarity");
  endtask

  task automatic testInputSweep();
    sendCmd(8'h80);
    readData(8'h55, "R8 bank 0");
    readData(8'h44, "R8 bank 1");
    readData(8'hF0, "R8 bank 2 inverted");
    readData(8'h22, "R8 bank 3");
    readData(8'h11, "R8 bank 4");
    readData(8'h55, "R3 R10 read wraps to bank 0");
  endtask

  task automatic testUnused();
    sendCmd(8'h0D);
    readData(8'h00, "R7 unused bank reads zero");
    writeData(8'h99, 1'b0, "R7 unused bank nack");
    check("R7 outPort untouched", outPort, 40'hA4_A3_A2_A1_A5);
    sendCmd(8'h8E);
    writeData(8'h99, 1'b0, "R7 unused bank nack with stepping");
    writeData(8'h66, 1'b1, "R3 unused code skips to bank 0");
    check("R3 bank 0 written after skip", outPort, 40'hA4_A3_A2_A1_66);
    sendCmd(8'hA8);
    readData(8'h00, "R7 group 5 reads zero");
    writeData(8'h12, 1'b0, "R7 group 5 nack");
    sendCmd(8'hB8);
    readData(8'h00, "R7 group 7 reads zero");
  endtask

  task automatic testCfgMask();
    sendCmd(8'h9B);
    writeData(8'h0F, 1'b1, "R5 direction write ack");
    check("R9 direction bank 3", ioCfg, 40'hFF_0F_FF_FF_FF);
    writeData(8'hF0, 1'b1, "R5 direction write ack");
    check("R3 R9 direction bank 4", ioCfg, 40'hF0_0F_FF_FF_FF);
    sendCmd(8'hA4);
    writeData(8'h12, 1'b1, "R5 mask write ack");
    check("R9 mask bank 4", intMask, 40'h12_FF_FF_FF_FF);
    readData(8'hFF, "R3 mask read after wrap to bank 0");
    sendCmd(8'hA4);
    readData(8'h12, "R2 R10 mask bank 4 readback");
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStepWrap();
    testNoStep();
    testInputWrite();
    testInputSweep();
    testUnused();
    testCfgMask();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule